// File: doc/BRIEF.md
# SPI Controller Register Front-End

This block is the bus-facing part of an SPI controller. It presents three 32-bit word registers to a simple request/acknowledge bus: a settings word (pin enable, chip-select level, clock idle level and phase, bit order, clock divider), a transfer word (chip-select mask plus write and read bit counts) and a data word. It holds the settings and hands them to a separate shift engine and clock generator, which are not part of this block.

A write to the data word loads the outgoing value and launches one transfer by pulsing a start strobe to the shift engine. The bus acknowledge for that write is held back until the engine reports completion, so the issuing master is stalled for the whole transfer. While the transfer runs, the chip-select lines named by the mask sit at the programmed active level; at all other times every line sits at the inactive level. The word captured by the engine replaces the data word and can be read back at any later time. When the offline bit is set, the output-enable for all SPI pins is dropped so the pads float.

The bus follows a valid/ready rule: the master raises `bus_req` with address, direction and write data, and holds all of them unchanged until it sees `bus_ack` high at a clock edge; that edge completes the access. Settings, transfer and unmapped accesses, and data reads, complete in the same cycle they are presented; a data write back-pressures until the transfer ends.

Top module: `spi_fe_top`

## Requirements
- R1: After reset the settings word reads 0x0004_0001 (offline set, divider 4, all mode bits 0), the transfer word reads 0, `spi_oe` is 0 and every `cs_lines` bit is 1.
- R2: Settings word layout: bit 0 offline, bit 1 chip-select active level, bit 2 clock idle level, bit 3 clock phase, bit 4 LSB-first, bits 31:16 divider; bits 15:5 read as 0. Bits 2, 3, 4 and 31:16 appear on `eng_clk_pol`, `eng_clk_phase`, `eng_lsb_first` and `eng_div`.
- R3: Transfer word layout: bits 15:0 chip-select mask, bits 21:16 write length, bits 29:24 read length, other bits read as 0; the lengths appear on `eng_wlen` and `eng_rlen`.
- R4: A length field written with a value above 32 is stored, read back and driven as 32.
- R5: Any access to address 0, 1 or 3, and any read of address 2, is acknowledged in the cycle it is presented; address 3 reads 0 and writes to it change nothing.
- R6: A write to address 2 raises `eng_start` for exactly one cycle, the cycle after the request is presented, with `eng_wdata` equal to the written word; this holds also when both lengths are 0.
- R7: The acknowledge for a write to address 2 comes in the cycle after the cycle in which `eng_done` is seen high, and never earlier.
- R8: From the start strobe until `eng_done` is taken, each `cs_lines` bit whose mask bit is 1 sits at the active level (bit 1 of the settings word) and the rest at the opposite level; outside that window every bit sits at the opposite level.
- R9: `spi_oe` equals the inverse of the offline bit.
- R10: Reading address 2 after a transfer returns the `eng_rdata` value present with `eng_done`, on every read until the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request (valid) |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 settings, 1 transfer, 2 data |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access completes at this edge (ready) |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| spi_oe | output | 1 | Output enable for all SPI pins |
| cs_lines | output | 16 | Chip-select pin levels |
| eng_start | output | 1 | One-cycle transfer launch to the shift engine |
| eng_done | input | 1 | Shift engine reports the transfer finished |
| eng_wdata | output | 32 | Outgoing word for the shift engine |
| eng_rdata | input | 32 | Captured word, valid with `eng_done` |
| eng_clk_pol | output | 1 | Clock idle level |
| eng_clk_phase | output | 1 | Clock phase select |
| eng_lsb_first | output | 1 | Bit order select |
| eng_div | output | 16 | Clock divider |
| eng_wlen | output | 6 | Write bit count, 0 to 32 |
| eng_rlen | output | 6 | Read bit count, 0 to 32 |

## Verification
The assertions assume a single well-behaved master that holds each request stable until acknowledged and never presents a new read while a data write is stalled, and an engine that raises `eng_done` only after a start strobe. The bench drives the bus through one task that keeps the request up until acknowledge and drops it right after, so no access overlaps a running transfer. Its engine model answers only to an observed start strobe, with a chosen delay including zero, so done never arrives outside a transfer.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;
  localparam int CS_W    = 16;
  localparam int LEN_W   = 6;
  localparam int DIV_W   = 16;
  localparam int MAX_LEN = 32;
  localparam int DIV_RST = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_CFG  = 2'd0,
    REG_XFER = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } ctl_st_e;

endpackage

// File: rtl/spi_fe_regs.sv
module spi_fe_regs #(
  parameter int DATA_W  = 32,
  parameter int CS_W    = 16,
  parameter int LEN_W   = 6,
  parameter int DIV_W   = 16,
  parameter int MAX_LEN = 32,
  parameter int DIV_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              xfer_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              offline,
  output logic              cs_pol,
  output logic              clk_pol,
  output logic              clk_phase,
  output logic              lsb_first,
  output logic [DIV_W-1:0]  div,
  output logic [CS_W-1:0]   cs_mask,
  output logic [LEN_W-1:0]  wlen,
  output logic [LEN_W-1:0]  rlen,
  output logic [DATA_W-1:0] cfg_word,
  output logic [DATA_W-1:0] xfer_word
);
  localparam int DIV_LSB  = 16;
  localparam int WLEN_LSB = 16;
  localparam int RLEN_LSB = 24;
  localparam int N_LEN    = 2;
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

  logic [4:0]       mode_q;
  logic [DIV_W-1:0] div_q;
  logic [CS_W-1:0]  mask_q;
  logic [LEN_W-1:0] len_q [N_LEN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 5'b00001;
      div_q  <= DIV_W'(DIV_RST);
    end else if (cfg_we) begin
      mode_q <= wdata[4:0];
      div_q  <= wdata[DIV_LSB +: DIV_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (xfer_we) mask_q <= wdata[CS_W-1:0];
  end

  for (genvar g = 0; g < N_LEN; g++) begin : g_len
    localparam int LSB = (g == 0) ? WLEN_LSB : RLEN_LSB;
    logic [LEN_W-1:0] raw;
    logic [LEN_W-1:0] capped;
    assign raw    = wdata[LSB +: LEN_W];
    assign capped = (raw > LEN_CAP) ? LEN_CAP : raw;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) len_q[g] <= '0;
      else if (xfer_we) len_q[g] <= capped;
    end
  end

  assign offline   = mode_q[0];
  assign cs_pol    = mode_q[1];
  assign clk_pol   = mode_q[2];
  assign clk_phase = mode_q[3];
  assign lsb_first = mode_q[4];
  assign div       = div_q;
  assign cs_mask   = mask_q;
  assign wlen      = len_q[0];
  assign rlen      = len_q[1];

  always_comb begin
    cfg_word = '0;
    cfg_word[4:0] = mode_q;
    cfg_word[DIV_LSB +: DIV_W] = div_q;
    xfer_word = '0;
    xfer_word[CS_W-1:0] = mask_q;
    xfer_word[WLEN_LSB +: LEN_W] = len_q[0];
    xfer_word[RLEN_LSB +: LEN_W] = len_q[1];
  end

  // R4
  len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wlen <= LEN_CAP) && (rlen <= LEN_CAP));

endmodule

// File: rtl/spi_fe_ctl.sv
module spi_fe_ctl
  import spi_fe_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] cfg_word,
  input  logic [DATA_W-1:0] xfer_word,
  output logic              cfg_we,
  output logic              xfer_we,
  output logic              eng_start,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] eng_rdata,
  output logic [DATA_W-1:0] data_word,
  output logic              busy
);
  reg_sel_e          sel;
  ctl_st_e           st_q;
  logic              start_q;
  logic [DATA_W-1:0] data_q;
  logic              data_wr;
  logic              quick;

  assign sel     = reg_sel_e'(addr);
  assign data_wr = req && we && (sel == REG_DATA);
  assign quick   = (st_q == ST_IDLE) && req && !data_wr;
  assign ack     = quick || (st_q == ST_FIN);
  assign cfg_we  = quick && we && (sel == REG_CFG);
  assign xfer_we = quick && we && (sel == REG_XFER);

  always_comb begin
    case (sel)
      REG_CFG:  rdata = cfg_word;
      REG_XFER: rdata = xfer_word;
      REG_DATA: rdata = data_q;
      default:  rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      start_q <= 1'b0;
      data_q  <= '0;
    end else begin
      start_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (data_wr) begin
          data_q  <= wdata;
          start_q <= 1'b1;
          st_q    <= ST_RUN;
        end
        ST_RUN: if (eng_done) begin
          data_q <= eng_rdata;
          st_q   <= ST_FIN;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign eng_start = start_q;
  assign data_word = data_q;
  assign busy      = (st_q == ST_RUN);

  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  // R7
  data_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && we && (sel == REG_DATA)) |-> $past(eng_done));

  // R8
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done) |=> !busy);

  // R5
  quick_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |-> ack);

endmodule

// File: rtl/spi_fe_csdrv.sv
module spi_fe_csdrv #(
  parameter int CS_W = 16
) (
  input  logic            active,
  input  logic            pol,
  input  logic [CS_W-1:0] mask,
  output logic [CS_W-1:0] lines
);
  for (genvar i = 0; i < CS_W; i++) begin : g_line
    assign lines[i] = (active && mask[i]) ? pol : !pol;
  end
endmodule

// File: rtl/spi_fe_top.sv
module spi_fe_top
  import spi_fe_pkg::*;
#(
  parameter int P_DATA_W  = DATA_W,
  parameter int P_CS_W    = CS_W,
  parameter int P_LEN_W   = LEN_W,
  parameter int P_DIV_W   = DIV_W,
  parameter int P_MAX_LEN = MAX_LEN,
  parameter int P_DIV_RST = DIV_RST
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [1:0]           bus_addr,
  input  logic [P_DATA_W-1:0]  bus_wdata,
  output logic                 bus_ack,
  output logic [P_DATA_W-1:0]  bus_rdata,
  output logic                 spi_oe,
  output logic [P_CS_W-1:0]    cs_lines,
  output logic                 eng_start,
  input  logic                 eng_done,
  output logic [P_DATA_W-1:0]  eng_wdata,
  input  logic [P_DATA_W-1:0]  eng_rdata,
  output logic                 eng_clk_pol,
  output logic                 eng_clk_phase,
  output logic                 eng_lsb_first,
  output logic [P_DIV_W-1:0]   eng_div,
  output logic [P_LEN_W-1:0]   eng_wlen,
  output logic [P_LEN_W-1:0]   eng_rlen
);
  logic                cfg_we, xfer_we, busy;
  logic                offline, cs_pol;
  logic [P_CS_W-1:0]   cs_mask;
  logic [P_DATA_W-1:0] cfg_word, xfer_word;

  spi_fe_regs #(
    .DATA_W(P_DATA_W), .CS_W(P_CS_W), .LEN_W(P_LEN_W),
    .DIV_W(P_DIV_W), .MAX_LEN(P_MAX_LEN), .DIV_RST(P_DIV_RST)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .xfer_we(xfer_we),
    .wdata(bus_wdata), .offline(offline), .cs_pol(cs_pol),
    .clk_pol(eng_clk_pol), .clk_phase(eng_clk_phase),
    .lsb_first(eng_lsb_first), .div(eng_div), .cs_mask(cs_mask),
    .wlen(eng_wlen), .rlen(eng_rlen),
    .cfg_word(cfg_word), .xfer_word(xfer_word)
  );

  spi_fe_ctl #(.DATA_W(P_DATA_W)) ctl_i (
    .clk(clk), .rst_n(rst_n), .req(bus_req), .we(bus_we),
    .addr(bus_addr), .wdata(bus_wdata), .ack(bus_ack), .rdata(bus_rdata),
    .cfg_word(cfg_word), .xfer_word(xfer_word),
    .cfg_we(cfg_we), .xfer_we(xfer_we), .eng_start(eng_start),
    .eng_done(eng_done), .eng_rdata(eng_rdata), .data_word(eng_wdata),
    .busy(busy)
  );

  spi_fe_csdrv #(.CS_W(P_CS_W)) csdrv_i (
    .active(busy), .pol(cs_pol), .mask(cs_mask), .lines(cs_lines)
  );

  assign spi_oe = !offline;

  // R9
  oe_offline_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && bus_we && (bus_addr == 2'd0)) |=> (spi_oe == !$past(bus_wdata[0])));

endmodule

// File: tb/spi_fe_top_tb_top.sv
module spi_fe_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ack;
  logic [31:0] bus_rdata;
  logic        spi_oe;
  logic [15:0] cs_lines;
  logic        eng_start;
  logic        eng_done = 1'b0;
  logic [31:0] eng_wdata;
  logic [31:0] eng_rdata = '0;
  logic        eng_clk_pol, eng_clk_phase, eng_lsb_first;
  logic [15:0] eng_div;
  logic [5:0]  eng_wlen, eng_rlen;

  int checks = 0, fails = 0, start_cnt = 0, eng_delay = 0;
  logic [31:0] eng_resp = '0, seen_wdata = '0;
  logic [15:0] cs_snap = '0;
  logic done_flag = 1'b0;

  always #4 clk = !clk;

  spi_fe_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .spi_oe(spi_oe), .cs_lines(cs_lines),
    .eng_start(eng_start), .eng_done(eng_done), .eng_wdata(eng_wdata),
    .eng_rdata(eng_rdata), .eng_clk_pol(eng_clk_pol),
    .eng_clk_phase(eng_clk_phase), .eng_lsb_first(eng_lsb_first),
    .eng_div(eng_div), .eng_wlen(eng_wlen), .eng_rlen(eng_rlen)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [31:0] expv;
    logic [3:0]  req;
  } vec_t;

  // reads check expv; writes only load. R1 reset, R2 settings, R3/R4 transfer word, R5 unmapped.
  localparam vec_t VECS [10] = '{
    '{1'b0, 2'd0, 32'h0,          32'h0004_0001, 4'd1},
    '{1'b0, 2'd1, 32'h0,          32'h0000_0000, 4'd1},
    '{1'b1, 2'd0, 32'hABCD_FFFE,  32'h0,         4'd2},
    '{1'b0, 2'd0, 32'h0,          32'hABCD_001E, 4'd2},
    '{1'b1, 2'd1, 32'h3F2A_A5C3,  32'h0,         4'd4},
    '{1'b0, 2'd1, 32'h0,          32'h2020_A5C3, 4'd4},
    '{1'b1, 2'd1, 32'hC018_0005,  32'h0,         4'd3},
    '{1'b1, 2'd3, 32'hFFFF_FFFF,  32'h0,         4'd5},
    '{1'b0, 2'd1, 32'h0,          32'h0018_0005, 4'd3},
    '{1'b0, 2'd3, 32'h0,          32'h0000_0000, 4'd5}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, expv);
    end
  endtask

  task automatic bus_op(input logic we, input logic [1:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; cyc = 0;
    #1;
    while (!bus_ack) begin
      @(negedge clk); #1; cyc++;
    end
    rd = bus_rdata;
    @(posedge clk); #1;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (eng_start) begin
        start_cnt++;
        seen_wdata = eng_wdata;
        for (int k = 0; k < eng_delay; k++) @(negedge clk);
        cs_snap = cs_lines;
        eng_rdata = eng_resp;
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cyc;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset pins
    chk("R1 cs idle", {16'h0, cs_lines}, 32'h0000_FFFF);
    chk("R1 oe", {31'h0, spi_oe}, 32'h0);
    chk("R1 div", {16'h0, eng_div}, 32'd4);

    foreach (VECS[i]) begin
      bus_op(VECS[i].we, VECS[i].addr, VECS[i].wdata, rd, cyc);
      chk($sformatf("R%0d ack cycles vec %0d", VECS[i].req, i), cyc, 0);
      if (!VECS[i].we)
        chk($sformatf("R%0d readback vec %0d", VECS[i].req, i), rd, VECS[i].expv);
      if (i == 4) begin
        // R4 clamped lengths on engine pins
        chk("R4 wlen", {26'h0, eng_wlen}, 32'd32);
        chk("R4 rlen", {26'h0, eng_rlen}, 32'd32);
      end
    end
    // R3 lengths after second transfer-word write
    chk("R3 wlen", {26'h0, eng_wlen}, 32'd24);
    chk("R3 rlen", {26'h0, eng_rlen}, 32'd0);

    // R2 settings pins, online, active-low chip select
    bus_op(1'b1, 2'd0, 32'h0003_001C, rd, cyc);
    chk("R2 mode pins", {29'h0, eng_clk_pol, eng_clk_phase, eng_lsb_first}, 32'h7);
    chk("R2 div", {16'h0, eng_div}, 32'd3);
    chk("R9 oe online", {31'h0, spi_oe}, 32'h1);

    // first transfer, delay 5, active-low
    eng_delay = 5; eng_resp = 32'hCAFE_F00D;
    bus_op(1'b1, 2'd2, 32'h1234_5678, rd, cyc);
    chk("R7 ack delay", cyc, 7);
    chk("R6 start count", start_cnt, 1);
    chk("R6 wdata", seen_wdata, 32'h1234_5678);
    chk("R8 cs during", {16'h0, cs_snap}, 32'h0000_FFFA);
    @(negedge clk);
    chk("R8 cs after", {16'h0, cs_lines}, 32'h0000_FFFF);
    bus_op(1'b0, 2'd2, 32'h0, rd, cyc);
    chk("R10 data read", rd, 32'hCAFE_F00D);
    chk("R5 data read ack", cyc, 0);

    // active-high, zero lengths, zero-delay engine
    bus_op(1'b1, 2'd0, 32'h0004_0002, rd, cyc);
    @(negedge clk);
    chk("R8 idle active-high", {16'h0, cs_lines}, 32'h0);
    bus_op(1'b1, 2'd1, 32'h0000_8001, rd, cyc);
    eng_delay = 0; eng_resp = 32'h0BAD_BEEF;
    bus_op(1'b1, 2'd2, 32'h0000_0000, rd, cyc);
    chk("R6 zero-length start", start_cnt, 2);
    chk("R7 ack delay zero", cyc, 2);
    chk("R8 cs active-high", {16'h0, cs_snap}, 32'h0000_8001);
    repeat (4) @(negedge clk);
    chk("R6 no extra start", start_cnt, 2);
    bus_op(1'b0, 2'd2, 32'h0, rd, cyc);
    chk("R10 read again 1", rd, 32'h0BAD_BEEF);
    bus_op(1'b0, 2'd0, 32'h0, rd, cyc);
    bus_op(1'b0, 2'd2, 32'h0, rd, cyc);
    chk("R10 read again 2", rd, 32'h0BAD_BEEF);

    // R9 offline again
    bus_op(1'b1, 2'd0, 32'h0004_0001, rd, cyc);
    @(negedge clk);
    chk("R9 oe offline", {31'h0, spi_oe}, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule